// File: doc/BRIEF.md
# Filter Group Status Aggregator

This block collects per-channel status from a set of filter channels and condenses it into the status of a single channel group. Each channel supplies three signals: a saturation flag, a limit-exceeded flag and a one-cycle pulse that marks a completed output write, meaning a valid write response has come back. A membership mask in a control register decides which channels belong to the group.

The block reports three things for the group. The first is a level that follows the OR of the saturation flags of the member channels. The second is a level that follows the OR of their limit flags. The third is a sticky vector-count status. This status sets each time a programmed number of complete sample vectors has been written out. A complete vector is one finished write from every member channel. Software clears the sticky status by writing a one to it. While the sticky status and its enable bit are both set, a trigger output stays high so that a consumer can be woken.

A small register port, with a write strobe, a read strobe and a two-bit address, gives software access to the control, modulo and status registers.

Top module: `gsa_top`

## Requirements
- R1: `grp_sat_o` and STAT bit 0 equal the OR of `ch_sat_i` over member channels, one clock after the inputs. Writes to STAT do not change this bit.
- R2: `grp_lim_o` and STAT bit 1 equal the OR of `ch_lim_i` over member channels, one clock after the inputs. Writes to STAT do not change this bit.
- R3: CTRL bits [NUM_CH-1:0] form the membership mask. Bit i set makes channel i a member. A group with an empty mask never completes a vector.
- R4: A vector completes in the clock in which every member channel has pulsed `ch_wresp_i` at least once since the last vector boundary. Pulses from non-members are ignored. Repeated pulses from the same channel within one vector count once.
- R5: STAT bit 2 sets at the end of every MOD-th completed vector, after which the count restarts. The MOD register is address 1. A MOD value of 0 behaves as 1.
- R6: STAT bit 2 is sticky. Writing 1 to STAT bit 2 clears it. Writing 0 to that bit leaves it unchanged.
- R7: When a set event and a write-1-to-clear fall in the same clock, STAT bit 2 ends up set.
- R8: `grp_trig_o` is high exactly while STAT bit 2 and the trigger enable (CTRL bit NUM_CH) are both 1. It changes in the same clock as the state that drives it.
- R9: A CTRL write that changes the membership mask discards the partial vector and restarts the vector count at zero.
- R10: After a synchronous reset, all registers, status bits and outputs are 0.
- R11: A read strobe returns the addressed register on `cfg_rdata_o` one clock later. The addresses are 0 for CTRL, 1 for MOD, 2 for STAT and 3 for an unused location that reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_sat_i | input | NUM_CH | Per-channel saturation flags |
| ch_lim_i | input | NUM_CH | Per-channel limit-exceeded flags |
| ch_wresp_i | input | NUM_CH | Per-channel write-completed pulses |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_re_i | input | 1 | Register read strobe |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | DATA_W | Register write data |
| cfg_rdata_o | output | DATA_W | Registered read data |
| grp_sat_o | output | 1 | Group saturation level |
| grp_lim_o | output | 1 | Group limit level |
| grp_trig_o | output | 1 | Group trigger |

## Verification
The bench builds the block with its defaults: four channels, an 8-bit modulo and a 32-bit data path. With four channels, a three-channel group with one non-member can be set up, so the bench can check ignored pulses, duplicate pulses and vectors that complete either in a single clock or spread over several. The 8-bit modulo allows small programmed counts such as 0, 1, 2 and 5, which makes the wrap point, the zero-as-one rule and the counter restart after a mask change reachable in a few dozen clocks.

// File: rtl/gsa_pkg.sv
package gsa_pkg;
  localparam int REG_AW = 2;
  typedef enum logic [REG_AW-1:0] {
    REG_CTRL = 2'd0,
    REG_MOD  = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;
  localparam int STAT_SAT_BIT  = 0;
  localparam int STAT_LIM_BIT  = 1;
  localparam int STAT_PCNT_BIT = 2;
endpackage

// File: rtl/gsa_vec_tracker.sv
module gsa_vec_tracker #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] mask_i,
  input  logic [NUM_CH-1:0] resp_i,
  input  logic              flush_i,
  output logic [NUM_CH-1:0] seen_o,
  output logic              vec_done_o
);
  logic [NUM_CH-1:0] seen_q;
  logic [NUM_CH-1:0] acc;

  // Accumulate responses of member channels only
  assign acc        = seen_q | (resp_i & mask_i);
  assign vec_done_o = (|mask_i) && (acc == mask_i) && !flush_i;
  assign seen_o     = seen_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_seen
    always_ff @(posedge clk) begin
      if (rst || flush_i || vec_done_o) seen_q[i] <= 1'b0;
      else                              seen_q[i] <= acc[i];
    end
  end
endmodule

// File: rtl/gsa_mod_counter.sv
module gsa_mod_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] modulo_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mod_eff;
  logic [EXT_W-1:0] cnt_inc;
  logic             at_last;

  assign mod_eff = (modulo_i == '0) ? CNT_W'(1) : modulo_i;
  assign cnt_inc = {1'b0, cnt_q} + EXT_W'(1);
  assign at_last = cnt_inc >= {1'b0, mod_eff};
  assign wrap_o  = step_i && at_last && !clr_i;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)  cnt_q <= '0;
    else if (step_i)   cnt_q <= at_last ? '0 : cnt_inc[CNT_W-1:0];
  end
endmodule

// File: rtl/gsa_regs.sv
module gsa_regs
  import gsa_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              grp_sat_i,
  input  logic              grp_lim_i,
  input  logic              pcnt_set_i,
  output logic [NUM_CH-1:0] mask_o,
  output logic              trig_en_o,
  output logic [CNT_W-1:0]  modulo_o,
  output logic              pcnt_o,
  output logic              mask_chg_o,
  output logic              w1c_o,
  output logic              trig_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [NUM_CH-1:0] mask_q;
  logic              en_q;
  logic [CNT_W-1:0]  mod_q;
  logic              pcnt_q;
  logic              trig_q;
  logic [DATA_W-1:0] rdata_q;

  logic ctrl_wr, mod_wr, stat_wr;
  logic pcnt_nxt, en_nxt;
  logic [DATA_W-1:0] rd_mux;

  assign ctrl_wr    = we_i && (addr_i == REG_CTRL);
  assign mod_wr     = we_i && (addr_i == REG_MOD);
  assign stat_wr    = we_i && (addr_i == REG_STAT);
  assign mask_chg_o = ctrl_wr && (wdata_i[NUM_CH-1:0] != mask_q);
  assign w1c_o      = stat_wr && wdata_i[STAT_PCNT_BIT];

  // Set has priority over clear
  assign pcnt_nxt = pcnt_set_i || (pcnt_q && !w1c_o);
  assign en_nxt   = ctrl_wr ? wdata_i[NUM_CH] : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      en_q   <= 1'b0;
      mod_q  <= '0;
      pcnt_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        mask_q <= wdata_i[NUM_CH-1:0];
        en_q   <= wdata_i[NUM_CH];
      end
      if (mod_wr) mod_q <= wdata_i[CNT_W-1:0];
      pcnt_q <= pcnt_nxt;
      trig_q <= pcnt_nxt && en_nxt;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      REG_CTRL: begin
        rd_mux[NUM_CH-1:0] = mask_q;
        rd_mux[NUM_CH]     = en_q;
      end
      REG_MOD:  rd_mux[CNT_W-1:0] = mod_q;
      REG_STAT: begin
        rd_mux[STAT_SAT_BIT]  = grp_sat_i;
        rd_mux[STAT_LIM_BIT]  = grp_lim_i;
        rd_mux[STAT_PCNT_BIT] = pcnt_q;
      end
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (re_i) rdata_q <= rd_mux;
  end

  assign mask_o    = mask_q;
  assign trig_en_o = en_q;
  assign modulo_o  = mod_q;
  assign pcnt_o    = pcnt_q;
  assign trig_o    = trig_q;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/gsa_top.sv
module gsa_top
  import gsa_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ch_sat_i,
  input  logic [NUM_CH-1:0] ch_lim_i,
  input  logic [NUM_CH-1:0] ch_wresp_i,
  input  logic              cfg_we_i,
  input  logic              cfg_re_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  output logic              grp_sat_o,
  output logic              grp_lim_o,
  output logic              grp_trig_o
);
  logic [NUM_CH-1:0] ctrl_mask;
  logic              trig_en;
  logic [CNT_W-1:0]  mod_val;
  logic [NUM_CH-1:0] seen_mask;
  logic [CNT_W-1:0]  vec_cnt;
  logic              vec_done;
  logic              pcnt_set;
  logic              pcnt_stat;
  logic              mask_chg;
  logic              w1c_pcnt;
  logic              sat_q, lim_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sat_q <= 1'b0;
      lim_q <= 1'b0;
    end else begin
      sat_q <= |(ch_sat_i & ctrl_mask);
      lim_q <= |(ch_lim_i & ctrl_mask);
    end
  end

  gsa_vec_tracker #(.NUM_CH(NUM_CH)) u_trk (
    .clk(clk), .rst(rst), .mask_i(ctrl_mask), .resp_i(ch_wresp_i),
    .flush_i(mask_chg), .seen_o(seen_mask), .vec_done_o(vec_done)
  );

  gsa_mod_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(mask_chg), .step_i(vec_done),
    .modulo_i(mod_val), .cnt_o(vec_cnt), .wrap_o(pcnt_set)
  );

  gsa_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .we_i(cfg_we_i), .re_i(cfg_re_i),
    .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .grp_sat_i(sat_q), .grp_lim_i(lim_q), .pcnt_set_i(pcnt_set),
    .mask_o(ctrl_mask), .trig_en_o(trig_en), .modulo_o(mod_val),
    .pcnt_o(pcnt_stat), .mask_chg_o(mask_chg), .w1c_o(w1c_pcnt),
    .trig_o(grp_trig_o), .rdata_o(cfg_rdata_o)
  );

  assign grp_sat_o = sat_q;
  assign grp_lim_o = lim_q;
endmodule

// File: rtl/gsa_checker.sv
module gsa_checker #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] ch_sat_i,
  input logic [NUM_CH-1:0] ch_lim_i,
  input logic [NUM_CH-1:0] ctrl_mask,
  input logic [NUM_CH-1:0] seen_mask,
  input logic [CNT_W-1:0]  vec_cnt,
  input logic              trig_en,
  input logic              pcnt_stat,
  input logic              pcnt_set,
  input logic              w1c_pcnt,
  input logic              mask_chg,
  input logic              grp_sat_o,
  input logic              grp_lim_o,
  input logic              grp_trig_o
);
  // R1
  sat_or_chk: assert property (@(posedge clk) disable iff (rst)
    grp_sat_o == $past(|(ch_sat_i & ctrl_mask)));
  // R2
  lim_or_chk: assert property (@(posedge clk) disable iff (rst)
    grp_lim_o == $past(|(ch_lim_i & ctrl_mask)));
  // R4
  seen_subset_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_mask & ~ctrl_mask) == '0);
  // R5
  wrap_restart_chk: assert property (@(posedge clk) disable iff (rst)
    pcnt_set |=> vec_cnt == '0);
  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pcnt_stat && !w1c_pcnt) |=> pcnt_stat);
  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    pcnt_set |=> pcnt_stat);
  // R8
  trig_and_chk: assert property (@(posedge clk) disable iff (rst)
    grp_trig_o == (pcnt_stat && trig_en));
  // R9
  mask_flush_chk: assert property (@(posedge clk) disable iff (rst)
    mask_chg |=> (vec_cnt == '0 && seen_mask == '0));
endmodule

bind gsa_top gsa_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ch_sat_i(ch_sat_i), .ch_lim_i(ch_lim_i),
  .ctrl_mask(ctrl_mask), .seen_mask(seen_mask), .vec_cnt(vec_cnt),
  .trig_en(trig_en), .pcnt_stat(pcnt_stat), .pcnt_set(pcnt_set),
  .w1c_pcnt(w1c_pcnt), .mask_chg(mask_chg), .grp_sat_o(grp_sat_o),
  .grp_lim_o(grp_lim_o), .grp_trig_o(grp_trig_o)
);

// File: tb/gsa_top_bench.sv
`timescale 1ns/1ps
module gsa_top_bench;
  localparam int NUM_CH = 4;
  localparam int CNT_W  = 8;
  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] EN = DATA_W'(1) << NUM_CH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_CH-1:0] ch_sat = '0, ch_lim = '0, ch_wresp = '0;
  logic cfg_we = 1'b0, cfg_re = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [DATA_W-1:0] cfg_wdata = '0;
  logic [DATA_W-1:0] cfg_rdata;
  logic grp_sat, grp_lim, grp_trig;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  gsa_top #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_gsa_top (
    .clk(clk), .rst(rst), .ch_sat_i(ch_sat), .ch_lim_i(ch_lim),
    .ch_wresp_i(ch_wresp), .cfg_we_i(cfg_we), .cfg_re_i(cfg_re),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .grp_sat_o(grp_sat), .grp_lim_o(grp_lim), .grp_trig_o(grp_trig)
  );

  task automatic chk(input string req, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk); cfg_re = 1'b1; cfg_addr = a;
    @(negedge clk); cfg_re = 1'b0; d = cfg_rdata;
  endtask

  task automatic resp(input logic [NUM_CH-1:0] m);
    @(negedge clk); ch_wresp = m;
    @(negedge clk); ch_wresp = '0;
  endtask

  task automatic t_reset();
    logic [DATA_W-1:0] d;
    chk("R10 sat", DATA_W'(grp_sat), 0);
    chk("R10 trig", DATA_W'(grp_trig), 0);
    rd(2'd2, d); chk("R10 STAT", d, 0);
    rd(2'd0, d); chk("R10 CTRL", d, 0);
    rd(2'd1, d); chk("R10 MOD", d, 0);
  endtask

  task automatic t_sat();
    logic [DATA_W-1:0] d;
    wr(2'd0, 32'h5);
    @(negedge clk); ch_sat = 4'b1010;
    @(negedge clk); chk("R1 R3 non-member sat", DATA_W'(grp_sat), 0);
    ch_sat = 4'b0100;
    @(negedge clk); chk("R1 member sat", DATA_W'(grp_sat), 1);
    wr(2'd2, 32'h0);
    rd(2'd2, d); chk("R1 STAT bit0 read-only", d & 1, 1);
    ch_sat = '0;
    @(negedge clk); chk("R1 sat drops", DATA_W'(grp_sat), 0);
  endtask

  task automatic t_lim();
    logic [DATA_W-1:0] d;
    @(negedge clk); ch_lim = 4'b0010;
    @(negedge clk); chk("R2 non-member lim", DATA_W'(grp_lim), 0);
    ch_lim = 4'b0001;
    @(negedge clk); chk("R2 member lim", DATA_W'(grp_lim), 1);
    wr(2'd2, 32'h3);
    rd(2'd2, d); chk("R2 STAT bits read-only", d, 32'h2);
    ch_lim = '0;
    @(negedge clk);
  endtask

  task automatic t_vec();
    wr(2'd0, 32'hB | EN);
    wr(2'd1, 32'd5);
    for (int v = 0; v < 4; v++) begin
      if (v % 2 == 0) begin
        resp(4'b0001); resp(4'b0010); resp(4'b1000);
      end else begin
        resp(4'b1011);
      end
    end
    chk("R5 no status after 4 vectors", DATA_W'(grp_trig), 0);
    resp(4'b1000); resp(4'b0011);
    chk("R5 R8 status after 5th vector", DATA_W'(grp_trig), 1);
  endtask

  task automatic t_w1c();
    logic [DATA_W-1:0] d;
    wr(2'd2, 32'h0);
    rd(2'd2, d); chk("R6 write 0 keeps status", (d >> 2) & 1, 1);
    wr(2'd2, 32'h4);
    chk("R6 W1C clears trig", DATA_W'(grp_trig), 0);
    rd(2'd2, d); chk("R6 W1C clears status", (d >> 2) & 1, 0);
  endtask

  task automatic t_ignore();
    wr(2'd1, 32'd1);
    resp(4'b0100);
    chk("R4 non-member ignored", DATA_W'(grp_trig), 0);
    resp(4'b0001); resp(4'b0001); resp(4'b0010);
    chk("R4 duplicate counted once", DATA_W'(grp_trig), 0);
    resp(4'b1000);
    chk("R4 vector completes", DATA_W'(grp_trig), 1);
    wr(2'd2, 32'h4);
  endtask

  task automatic t_modzero();
    wr(2'd1, 32'd0);
    resp(4'b1011);
    chk("R5 MOD 0 as 1 first", DATA_W'(grp_trig), 1);
    wr(2'd2, 32'h4);
    resp(4'b1011);
    chk("R5 MOD 0 as 1 second", DATA_W'(grp_trig), 1);
    wr(2'd2, 32'h4);
  endtask

  task automatic t_setwins();
    logic [DATA_W-1:0] d;
    wr(2'd1, 32'd1);
    resp(4'b1011);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 32'h4; ch_wresp = 4'b1011;
    @(negedge clk);
    cfg_we = 1'b0; ch_wresp = '0;
    rd(2'd2, d); chk("R7 set wins over clear", (d >> 2) & 1, 1);
  endtask

  task automatic t_trig_en();
    logic [DATA_W-1:0] d;
    wr(2'd0, 32'hB);
    chk("R8 trig low when disabled", DATA_W'(grp_trig), 0);
    rd(2'd2, d); chk("R8 status kept while disabled", (d >> 2) & 1, 1);
    wr(2'd0, 32'hB | EN);
    chk("R8 trig high when enabled", DATA_W'(grp_trig), 1);
    wr(2'd2, 32'h4);
  endtask

  task automatic t_mask();
    wr(2'd0, 32'h3 | EN);
    wr(2'd1, 32'd2);
    resp(4'b0011);
    resp(4'b0001);
    wr(2'd0, 32'h2 | EN);
    resp(4'b0010);
    chk("R9 counter restarted", DATA_W'(grp_trig), 0);
    resp(4'b0010);
    chk("R9 second vector sets", DATA_W'(grp_trig), 1);
  endtask

  task automatic t_regs();
    logic [DATA_W-1:0] d;
    rd(2'd0, d); chk("R11 CTRL read", d, 32'h2 | EN);
    rd(2'd1, d); chk("R11 MOD read", d, 32'd2);
    rd(2'd3, d); chk("R11 unused reads 0", d, 0);
    wr(2'd0, 32'h0);
    resp(4'b1111);
    rd(2'd2, d); chk("R3 empty mask keeps status", (d >> 2) & 1, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sat();
    t_lim();
    t_vec();
    t_w1c();
    t_ignore();
    t_modzero();
    t_setwins();
    t_trig_en();
    t_mask();
    t_regs();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule